// File: doc/BRIEF.md
# I2C Master Arbitration and Error Monitor

This block sits beside the shift register of an I2C master transmitter. On every SCL rising edge it compares the bit the master is putting out with the level seen on SDA. If the master drives high and the bus reads low, another master has won the bus. The block raises a sticky arbitration-lost flag. In that same cycle it also stops pulling SCL and SDA low, so both lines float, and it keeps them released until a stop condition or a clear.

The monitor also samples SDA into a capture register on the eight data clocks of each byte. On the falling edge of the ninth clock it marks the end of the byte. At that point it compares the captured byte with the byte loaded for transmission and flags a transmission error if they differ. An interrupt strobe fires at each byte end and after each stop detection, so software reads the flags at a fixed point. Generating the clock, start and stop conditions is left to the surrounding master.

Top module: `i2c_arb_monitor`

## Requirements
- R1: On a driven bit where `tx_bit_i`=1 and `sda_i`=1 at `scl_rise_i`, `lost_o` stays 0. While not released, `sda_oe_o` equals `drv_en_i & ~tx_bit_i` and `scl_oe_o` equals `scl_pull_i`.
- R2: A cycle with `scl_rise_i`=1, `drv_en_i`=1, `tx_bit_i`=1 and `sda_i`=0 (while the lines are not already released) is a loss. `lost_o` reads 1 from the next cycle on.
- R3: In the loss cycle, and from then on until `stop_det_i`, `lost_clr_i` or `start_req_i`, both `scl_oe_o` and `sda_oe_o` are 0 whatever the master requests (1 = pull line low).
- R4: No loss is detected on a bit with `drv_en_i`=0 (for example the acknowledge bit) or with `tx_bit_i`=0, whatever `sda_i` reads.
- R5: `lost_o` is sticky. Only `lost_clr_i` or `start_req_i` clears it, effective the next cycle. A stop releases the lines but leaves `lost_o` set.
- R6: `sda_i` is captured MSB first on rising edges 1 to 8 after `load_i`. The `scl_fall_i` that follows the 9th rise ends the byte, and `byte_end_o` pulses for one cycle on the next cycle. `tx_err_o` is set at that pulse if a byte was loaded, no loss occurred in that byte, and the captured byte differs from `tx_byte_i` as loaded.
- R7: `tx_err_o` stays set until `load_i`, which clears it from the next cycle.
- R8: `irq_o` pulses together with every `byte_end_o`, and for one cycle in the cycle after `stop_det_i`.
- R9: After reset, all outputs are 0.
- R10: `stop_det_i` or `start_req_i` aborts the byte in progress. A partial byte produces no `byte_end_o` and no error check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new byte for transmission; clears the error flag |
| tx_byte_i | input | BYTE_W | Byte being loaded |
| start_req_i | input | 1 | New start request; clears loss state, aborts the byte |
| lost_clr_i | input | 1 | Software clear of the arbitration-lost flag |
| stop_det_i | input | 1 | Stop condition detected on the bus |
| scl_rise_i | input | 1 | One-cycle strobe at an SCL rising edge |
| scl_fall_i | input | 1 | One-cycle strobe at an SCL falling edge |
| scl_pull_i | input | 1 | Master requests SCL low |
| drv_en_i | input | 1 | Master drives SDA on this bit |
| tx_bit_i | input | 1 | Bit the master drives |
| sda_i | input | 1 | Sampled SDA level |
| scl_oe_o | output | 1 | SCL open-drain pull-down enable |
| sda_oe_o | output | 1 | SDA open-drain pull-down enable |
| lost_o | output | 1 | Sticky arbitration-lost flag |
| tx_err_o | output | 1 | Sticky transmission-error flag |
| byte_end_o | output | 1 | One-cycle byte-end strobe |
| irq_o | output | 1 | Interrupt strobe |

## Verification
A missed or late loss decision would show first at the open-drain enables. A master still pulling SDA or SCL in the losing cycle differs from the release expected in that very cycle. A wrong sticky or hold state shows one cycle later on `lost_o`, or as an enable coming back before the stop. A bit counter that is off by one or a wrong capture stays hidden until the byte end: `byte_end_o`, `irq_o` or `tx_err_o` then appears in the wrong cycle or with the wrong value. The reference model is compared against every output on every clock, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int DEF_BYTE_W = 8;

  // counter must hold 0..byte_w+1 (data bits plus acknowledge)
  function automatic int cnt_width(input int byte_w);
    return $clog2(byte_w + 2);
  endfunction
endpackage

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_rise_i,
  input  logic drv_en_i,
  input  logic tx_bit_i,
  input  logic sda_i,
  input  logic stop_i,
  input  logic clr_i,
  output logic lose_now_o,
  output logic release_o,
  output logic lost_o
);
  logic lost_q, hold_q;

  assign lose_now_o = scl_rise_i & drv_en_i & tx_bit_i & ~sda_i & ~hold_q;
  assign release_o  = hold_q | lose_now_o;
  assign lost_o     = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (clr_i)           lost_q <= 1'b0;
      else if (lose_now_o) lost_q <= 1'b1;
      if (clr_i || stop_i) hold_q <= 1'b0;
      else if (lose_now_o) hold_q <= 1'b1;
    end
  end

  a_r2_flag_after_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lose_now_o && !clr_i |=> lost_o);
  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o && !clr_i |=> lost_o);
  a_r3_hold_until_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !stop_i && !clr_i |=> release_o);
  a_r4_no_loss_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_en_i || !tx_bit_i) |-> !lose_now_o);
endmodule

// File: rtl/i2c_byte_check.sv
module i2c_byte_check #(
  parameter int BYTE_W = i2c_arb_pkg::DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              abort_i,
  input  logic              lose_now_i,
  output logic              byte_end_o,
  output logic              tx_err_o
);
  localparam int CNT_W = i2c_arb_pkg::cnt_width(BYTE_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] cap_q, ref_q;
  logic              armed_q, lost_byte_q, err_q, end_q;
  logic              end_now;

  assign end_now    = scl_fall_i & (cnt_q == LAST) & ~load_i & ~abort_i;
  assign byte_end_o = end_q;
  assign tx_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      cap_q       <= '0;
      ref_q       <= '0;
      armed_q     <= 1'b0;
      lost_byte_q <= 1'b0;
      err_q       <= 1'b0;
      end_q       <= 1'b0;
    end else begin
      end_q <= end_now;
      if (load_i) begin
        ref_q       <= tx_byte_i;
        cap_q       <= '0;
        cnt_q       <= '0;
        armed_q     <= 1'b1;
        lost_byte_q <= 1'b0;
        err_q       <= 1'b0;
      end else if (abort_i) begin
        cnt_q       <= '0;
        armed_q     <= 1'b0;
        lost_byte_q <= 1'b0;
      end else begin
        if (scl_rise_i && cnt_q < LAST) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < DATA_LAST) cap_q <= {cap_q[BYTE_W-2:0], sda_i};
        end
        if (lose_now_i) lost_byte_q <= 1'b1;
        if (end_now) begin
          cnt_q       <= '0;
          armed_q     <= 1'b0;
          lost_byte_q <= 1'b0;
          if (armed_q && !lost_byte_q && cap_q != ref_q) err_q <= 1'b1;
        end
      end
    end
  end

  a_r6_err_rises_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_err_o) |-> byte_end_o);
  a_r7_err_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !end_now |=> $stable(tx_err_o));
  a_r10_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r10_abort_no_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !byte_end_o);
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int BYTE_W = i2c_arb_pkg::DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              start_req_i,
  input  logic              lost_clr_i,
  input  logic              stop_det_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              scl_pull_i,
  input  logic              drv_en_i,
  input  logic              tx_bit_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              lost_o,
  output logic              tx_err_o,
  output logic              byte_end_o,
  output logic              irq_o
);
  logic lose_now, release_lines, stop_q;

  i2c_arb_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise_i),
    .drv_en_i   (drv_en_i),
    .tx_bit_i   (tx_bit_i),
    .sda_i      (sda_i),
    .stop_i     (stop_det_i),
    .clr_i      (lost_clr_i | start_req_i),
    .lose_now_o (lose_now),
    .release_o  (release_lines),
    .lost_o     (lost_o)
  );

  i2c_byte_check #(.BYTE_W(BYTE_W)) u_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .tx_byte_i  (tx_byte_i),
    .scl_rise_i (scl_rise_i),
    .scl_fall_i (scl_fall_i),
    .sda_i      (sda_i),
    .abort_i    (stop_det_i | start_req_i),
    .lose_now_i (lose_now),
    .byte_end_o (byte_end_o),
    .tx_err_o   (tx_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= 1'b0;
    else         stop_q <= stop_det_i;
  end

  assign scl_oe_o = scl_pull_i & ~release_lines;
  assign sda_oe_o = drv_en_i & ~tx_bit_i & ~release_lines;
  assign irq_o    = byte_end_o | stop_q;

  a_r3_lines_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_lines |-> !scl_oe_o && !sda_oe_o);
  a_r8_irq_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_end_o |-> irq_o);
  a_r8_irq_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> irq_o);
endmodule

// File: tb/i2c_arb_monitor_bench.sv
`timescale 1ns/1ps
module i2c_arb_monitor_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       load = 0, start_req = 0, lost_clr = 0, stop_det = 0;
  logic       rise = 0, fall = 0, pull = 0, drv = 0, txb = 0, sda = 1;
  logic [7:0] txbyte = 8'h00;
  logic       scl_oe, sda_oe, lost, err, bend, irq;

  i2c_arb_monitor u_i2c_arb_monitor (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .tx_byte_i(txbyte),
    .start_req_i(start_req), .lost_clr_i(lost_clr), .stop_det_i(stop_det),
    .scl_rise_i(rise), .scl_fall_i(fall), .scl_pull_i(pull),
    .drv_en_i(drv), .tx_bit_i(txb), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .lost_o(lost), .tx_err_o(err),
    .byte_end_o(bend), .irq_o(irq)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R9";

  // behavioural reference state
  bit   m_lost, m_hold, m_armed, m_lostb, m_err, m_end, m_stop;
  int   m_cnt;
  bit   m_cap[$];
  byte  m_ref;

  task automatic chk(string nm, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit lose, rel, abort, endn;
    byte capb;
    #2;
    lose = rise && drv && txb && !sda && !m_hold;
    rel  = m_hold || lose;
    chk("scl_oe", scl_oe, rst_n && pull && !rel);
    chk("sda_oe", sda_oe, rst_n && drv && !txb && !rel);
    chk("lost", lost, m_lost);
    chk("tx_err", err, m_err);
    chk("byte_end", bend, m_end);
    chk("irq", irq, m_end || m_stop);
    if (!rst_n) begin
      {m_lost, m_hold, m_armed, m_lostb, m_err, m_end, m_stop} = '0;
      m_cnt = 0; m_cap.delete(); m_ref = 0;
    end else begin
      abort = stop_det || start_req;
      endn  = fall && m_cnt == 9 && !load && !abort;
      if (lost_clr || start_req) m_lost = 0; else if (lose) m_lost = 1;
      if (lost_clr || start_req || stop_det) m_hold = 0; else if (lose) m_hold = 1;
      m_stop = stop_det;
      m_end  = endn;
      if (load) begin
        m_ref = txbyte; m_cap.delete(); m_cnt = 0;
        m_armed = 1; m_lostb = 0; m_err = 0;
      end else if (abort) begin
        m_cnt = 0; m_armed = 0; m_lostb = 0;
      end else begin
        if (rise && m_cnt < 9) begin
          if (m_cnt < 8) m_cap.push_back(sda);
          m_cnt++;
        end
        if (lose) m_lostb = 1;
        if (endn) begin
          capb = 0;
          foreach (m_cap[i]) capb = {capb[6:0], m_cap[i]};
          if (m_armed && !m_lostb && capb != m_ref) m_err = 1;
          m_cnt = 0; m_armed = 0; m_lostb = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic one_bit(bit d, bit t, bit s);
    drv = d; txb = t; sda = s;
    pull = 0; rise = 1; tick(); rise = 0;
    tick();
    fall = 1; tick(); fall = 0;
    pull = 1; tick();
  endtask

  // bus[i] is what SDA reads; the master stops driving once released
  task automatic send_byte(byte tx, byte bus, bit ack);
    txbyte = tx; load = 1; tick(); load = 0;
    for (int i = 7; i >= 0; i--) one_bit(!m_hold, tx[i], bus[i]);
    one_bit(0, 1, ack);
    drv = 0;
  endtask

  initial begin
    #(64'd200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R9"; idle(3);          // reset state
    rst_n = 1; pull = 1;
    idle(2);
    cur_req = "R1"; send_byte(8'hA5, 8'hA5, 0);      // clean byte, no loss
    cur_req = "R8"; idle(2);
    cur_req = "R6"; send_byte(8'h3C, 8'h3D, 1);      // low bit read high: error, not loss
    cur_req = "R4"; one_bit(0, 1, 0);                // undriven bit with SDA low
    one_bit(1, 0, 0);
    cur_req = "R7"; idle(3);
    txbyte = 8'h11; load = 1; tick(); load = 0; idle(2);
    stop_det = 1; tick(); stop_det = 0; idle(2);
    cur_req = "R2"; send_byte(8'hF0, 8'hB0, 0);      // lose on second bit
    cur_req = "R3"; idle(3);
    cur_req = "R5"; stop_det = 1; tick(); stop_det = 0; idle(3);
    lost_clr = 1; tick(); lost_clr = 0; idle(2);
    cur_req = "R2"; send_byte(8'hFF, 8'h7F, 0);
    cur_req = "R5"; start_req = 1; tick(); start_req = 0; idle(2);
    cur_req = "R10";
    txbyte = 8'h55; load = 1; tick(); load = 0;
    for (int i = 0; i < 5; i++) one_bit(1, i[0], !i[0]);
    stop_det = 1; tick(); stop_det = 0;
    for (int i = 0; i < 5; i++) one_bit(0, 1, 1);
    cur_req = "R6"; send_byte(8'h80, 8'h80, 0);
    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule